// File: doc/BRIEF.md
# Iterative Bit Gather and Scatter Unit

This block performs two bit-permutation operations on 32-bit words using one shared iterative datapath. In gather mode it selects the source bits that sit under the set bits of a mask and packs them into the low end of the result. In scatter mode it works the other way round. It takes the low-order source bits one after another and places them, in order, at the positions of the mask's set bits. All other result bits are zero.

A caller raises `start` for one cycle while the unit is idle, with the operation, source and mask presented in that cycle. The unit then handles one mask bit per clock, lowest bit first. It stops as soon as no set mask bits remain, so short masks finish early. When it stops it raises `done` for one cycle, and `result` holds its value until the next accepted start. No condition flags are produced.

Top module: `bitpack_unit`

## Requirements
- R1: While reset is high and in the first cycle after it is released, `busy` and `done` are 0 and `result` is 0.
- R2: With `opSel` = 0 (gather), the result's bit k equals the source bit under the k-th lowest set mask bit. Bits above the number of set mask bits are zero.
- R3: With `opSel` = 1 (scatter), the result bit at the position of the k-th lowest set mask bit equals source bit k. Result bits where the mask is zero are zero.
- R4: A zero mask gives a zero result in either mode, and any stale result from an earlier operation is cleared when a new operation is accepted.
- R5: `done` rises exactly L rising edges after the edge that accepts `start`, where L is one plus the index of the highest set mask bit, or 1 for a zero mask. `busy` is 1 from the accepting edge until the edge where `done` rises, and it is 0 in the cycle where `done` is 1.
- R6: `done` is a single-cycle pulse and is only raised directly after a cycle in which `busy` was 1.
- R7: `start` has no effect while `busy` is 1. The operation, source and mask are taken only in the accepting cycle, and later changes to those inputs do not alter the result.
- R8: After `done`, `result` stays unchanged until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request a new operation; accepted only when idle |
| opSel | input | 1 | 0 = gather (extract), 1 = scatter (deposit) |
| srcIn | input | 32 | Source word |
| maskIn | input | 32 | Selection mask |
| result | output | 32 | Operation result, valid from the `done` cycle onward |
| busy | output | 1 | High while an operation is in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The only timing that depends on the data is the completion edge. It is one to thirty-two edges after the accepting edge, set by the highest set mask bit. The bench gives each vector its expected edge count, counts rising edges from acceptance, and reads `done` and `result` one time unit after each edge. The completion count and the result are therefore checked against the same edge at which the design registers them. One edge later the bench confirms that the pulse has ended and the result is still held. The stale-input test changes the inputs right after acceptance and raises `start` in the middle of the run, then checks that neither the count nor the value moves.

// File: rtl/bitpack_pkg.sv
package bitpack_pkg;

  typedef enum logic [0:0] {
    OP_GATHER  = 1'b0,
    OP_SCATTER = 1'b1
  } op_e;

  typedef struct packed {
    logic load;  // capture operands, clear result and write pointer
    logic step;  // process one mask bit
  } ctrl_t;

endpackage

// File: rtl/bitpack_ctrl.sv
module bitpack_ctrl
  import bitpack_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  start,
  input  logic  maskLast,
  output ctrl_t strobe,
  output logic  busy,
  output logic  done
);

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } state_e;

  state_e state;
  state_e stateNext;
  logic   doneNext;

  always_comb begin
    stateNext   = state;
    doneNext    = 1'b0;
    strobe.load = 1'b0;
    strobe.step = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          strobe.load = 1'b1;
          stateNext   = ST_RUN;
        end
      end
      ST_RUN: begin
        strobe.step = 1'b1;
        if (maskLast) begin
          doneNext  = 1'b1;
          stateNext = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      state <= stateNext;
      done  <= doneNext;
    end
  end

  assign busy = (state == ST_RUN);

endmodule

// File: rtl/bitpack_dpath.sv
module bitpack_dpath
  import bitpack_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  ctrl_t            strobe,
  input  op_e              opIn,
  input  logic [WIDTH-1:0] srcIn,
  input  logic [WIDTH-1:0] maskIn,
  output logic             maskLast,
  output logic [WIDTH-1:0] result
);

  localparam int PTR_W = $clog2(WIDTH);

  op_e              opReg;
  logic [WIDTH-1:0] srcReg;
  logic [WIDTH-1:0] maskReg;
  logic [WIDTH-1:0] resReg;
  logic [PTR_W-1:0] wrPtr;
  logic [WIDTH-1:0] wrHit;
  logic             takeBit;
  logic             advSrc;
  logic             advPtr;

  // A set mask LSB during a step means the current source LSB is written
  assign takeBit = strobe.step & maskReg[0];

  // Pointer policy: the only difference between the two operations
  always_comb begin
    if (opReg == OP_GATHER) begin
      advSrc = 1'b1;
      advPtr = maskReg[0];
    end else begin
      advSrc = maskReg[0];
      advPtr = 1'b1;
    end
  end

  // Per-bit write decode of the pointer
  for (genvar i = 0; i < WIDTH; i++) begin : g_wrDec
    assign wrHit[i] = takeBit & (wrPtr == PTR_W'(i));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      opReg   <= OP_GATHER;
      srcReg  <= '0;
      maskReg <= '0;
      wrPtr   <= '0;
    end else if (strobe.load) begin
      opReg   <= opIn;
      srcReg  <= srcIn;
      maskReg <= maskIn;
      wrPtr   <= '0;
    end else if (strobe.step) begin
      maskReg <= maskReg >> 1;
      if (advSrc) srcReg <= srcReg >> 1;
      if (advPtr) wrPtr  <= wrPtr + PTR_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst || strobe.load) begin
      resReg <= '0;
    end else begin
      resReg <= (resReg & ~wrHit) | (wrHit & {WIDTH{srcReg[0]}});
    end
  end

  // True when no set bit remains above the one being examined
  assign maskLast = ~|maskReg[WIDTH-1:1];
  assign result   = resReg;

endmodule

// File: rtl/bitpack_unit.sv
module bitpack_unit
  import bitpack_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             opSel,
  input  logic [WIDTH-1:0] srcIn,
  input  logic [WIDTH-1:0] maskIn,
  output logic [WIDTH-1:0] result,
  output logic             busy,
  output logic             done
);

  ctrl_t strobe;
  logic  maskLast;

  bitpack_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .maskLast (maskLast),
    .strobe   (strobe),
    .busy     (busy),
    .done     (done)
  );

  bitpack_dpath #(.WIDTH(WIDTH)) u_dpath (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .opIn     (op_e'(opSel)),
    .srcIn    (srcIn),
    .maskIn   (maskIn),
    .maskLast (maskLast),
    .result   (result)
  );

endmodule

// File: rtl/bitpack_checker.sv
module bitpack_checker #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic [WIDTH-1:0] result
);

  localparam int CNT_W = $clog2(WIDTH) + 2;

  logic [CNT_W-1:0] busyCnt;

  always_ff @(posedge clk) begin
    if (rst)       busyCnt <= '0;
    else if (busy) busyCnt <= busyCnt + CNT_W'(1);
    else           busyCnt <= '0;
  end

  AST_RESET_IDLE: assert property (@(posedge clk) rst |=> (!busy && !done)); // R1
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R6
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (rst) done |-> $past(busy)); // R6
  AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (rst) !(busy && done)); // R5
  AST_START_ACCEPT: assert property (@(posedge clk) disable iff (rst) (start && !busy) |=> busy); // R5
  AST_LATENCY_BOUND: assert property (@(posedge clk) disable iff (rst) busy |-> (busyCnt < CNT_W'(WIDTH))); // R5
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst) (!busy && !done) |-> $stable(result)); // R8

endmodule

bind bitpack_unit bitpack_checker #(.WIDTH(WIDTH)) u_bitpackChk (
  .clk    (clk),
  .rst    (rst),
  .start  (start),
  .busy   (busy),
  .done   (done),
  .result (result)
);

// File: tb/bitpack_unit_bench.sv
module bitpack_unit_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 16;

  typedef struct packed {
    logic        op;
    logic [31:0] src;
    logic [31:0] mask;
    logic [31:0] exp;
    logic [7:0]  lat;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{1'b0, 32'hFFFF_FFFF, 32'h0000_00F0, 32'h0000_000F, 8'd8},
    '{1'b0, 32'h1234_5678, 32'hFFFF_0000, 32'h0000_1234, 8'd32},
    '{1'b0, 32'hA5A5_A5A5, 32'h0000_000F, 32'h0000_0005, 8'd4},
    '{1'b0, 32'h8000_0001, 32'h8000_0001, 32'h0000_0003, 8'd32},
    '{1'b0, 32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_0000, 8'd32},
    '{1'b0, 32'hDEAD_BEEF, 32'hFFFF_FFFF, 32'hDEAD_BEEF, 8'd32},
    '{1'b0, 32'h0000_00AA, 32'h0000_00AA, 32'h0000_000F, 8'd8},
    '{1'b0, 32'hF0F0_F0F0, 32'h0000_FF00, 32'h0000_00F0, 8'd16},
    '{1'b0, 32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_0000, 8'd1},
    '{1'b1, 32'h0000_000F, 32'hF000_0000, 32'hF000_0000, 8'd32},
    '{1'b1, 32'h0000_0005, 32'h0000_0F00, 32'h0000_0500, 8'd12},
    '{1'b1, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0001, 8'd1},
    '{1'b1, 32'h0000_0002, 32'h8000_0001, 32'h8000_0000, 8'd32},
    '{1'b1, 32'hDEAD_BEEF, 32'hFFFF_FFFF, 32'hDEAD_BEEF, 8'd32},
    '{1'b1, 32'h0000_000F, 32'h0000_00AA, 32'h0000_00AA, 8'd8},
    '{1'b1, 32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_0000, 8'd1}
  };

  logic        clk = 1'b0;
  logic        rst;
  logic        start;
  logic        opSel;
  logic [31:0] srcIn;
  logic [31:0] maskIn;
  logic [31:0] result;
  logic        busy;
  logic        done;

  int nChecks = 0;
  int nFails  = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  bitpack_unit u_bitpack_unit (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .opSel  (opSel),
    .srcIn  (srcIn),
    .maskIn (maskIn),
    .result (result),
    .busy   (busy),
    .done   (done)
  );

  task automatic check(input logic ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", tag, act, exp, $time);
    end
  endtask

  // Start one operation and count edges until done; inputs are scrambled
  // right after acceptance so that only captured values may matter (R7).
  task automatic runOp(input logic op, input logic [31:0] src, input logic [31:0] mask,
                       output logic [31:0] res, output int lat);
    @(negedge clk);
    start  = 1'b1;
    opSel  = op;
    srcIn  = src;
    maskIn = mask;
    @(posedge clk);
    #1;
    start  = 1'b0;
    opSel  = ~op;
    srcIn  = ~src;
    maskIn = ~mask;
    lat = 0;
    while (!done && lat < 40) begin
      @(posedge clk);
      #1;
      lat++;
    end
    res = result;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nFails++;
    $display("FAIL watchdog: run did not complete");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [31:0] res;
    int          lat;
    logic [31:0] held;

    rst = 1'b1; start = 1'b0; opSel = 1'b0; srcIn = '0; maskIn = '0;
    repeat (3) @(posedge clk);
    #1;
    check(busy == 1'b0, "R1 busy in reset", 32'(busy), 32'd0);
    check(done == 1'b0, "R1 done in reset", 32'(done), 32'd0);
    check(result == 32'd0, "R1 result in reset", result, 32'd0);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    #1;
    check(!busy && !done && result == 32'd0, "R1 after release", result, 32'd0);

    for (int v = 0; v < NV; v++) begin
      string tag;
      tag = (VECS[v].mask == 32'd0) ? "R4" : (VECS[v].op ? "R3" : "R2");
      runOp(VECS[v].op, VECS[v].src, VECS[v].mask, res, lat);
      check(res == VECS[v].exp, tag, res, VECS[v].exp);
      check(lat == int'(VECS[v].lat), "R5 latency", 32'(lat), 32'(VECS[v].lat));
      check(!busy, "R5 busy low at done", 32'(busy), 32'd0);
      held = result;
      @(posedge clk);
      #1;
      check(!done, "R6 done single pulse", 32'(done), 32'd0);
      check(result == held, "R8 result held", result, held);
    end

    // R8: idle for several cycles with changing inputs, result must not move
    runOp(1'b0, 32'h1234_5678, 32'hFFFF_0000, res, lat);
    repeat (5) begin
      @(negedge clk);
      srcIn  = srcIn + 32'h1111_1111;
      maskIn = maskIn ^ 32'h0F0F_0F0F;
    end
    @(posedge clk);
    #1;
    check(result == 32'h0000_1234, "R8 idle hold", result, 32'h0000_1234);

    // R4: a zero-mask run after a nonzero result clears the stale value
    runOp(1'b1, 32'hFFFF_FFFF, 32'h0000_0000, res, lat);
    check(res == 32'd0, "R4 stale cleared", res, 32'd0);

    // R7: start raised while busy has no effect on value or timing
    @(negedge clk);
    start = 1'b1; opSel = 1'b0; srcIn = 32'h1234_5678; maskIn = 32'hFFFF_0000;
    @(posedge clk);
    #1;
    start = 1'b0;
    lat = 0;
    repeat (3) begin
      @(posedge clk);
      #1;
      lat++;
    end
    start = 1'b1; opSel = 1'b1; srcIn = 32'h0000_0000; maskIn = 32'h0000_000F;
    repeat (2) begin
      @(posedge clk);
      #1;
      lat++;
    end
    start = 1'b0;
    check(busy == 1'b1, "R7 still busy", 32'(busy), 32'd1);
    while (!done && lat < 40) begin
      @(posedge clk);
      #1;
      lat++;
    end
    check(result == 32'h0000_1234, "R7 result", result, 32'h0000_1234);
    check(lat == 32, "R7 latency", 32'(lat), 32'd32);
    @(posedge clk);
    #1;
    check(!busy && !done, "R7 no restart", 32'(busy), 32'd0);

    // R1: reset in the middle of a run returns to idle with a zero result
    runOp(1'b0, 32'hFFFF_FFFF, 32'h0000_00FF, res, lat);
    @(negedge clk);
    start = 1'b1; opSel = 1'b0; srcIn = 32'hFFFF_FFFF; maskIn = 32'hFFFF_FFFF;
    @(negedge clk);
    start = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    check(!busy && !done && result == 32'd0, "R1 mid-run reset", result, 32'd0);
    @(negedge clk);
    rst = 1'b0;

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule